// File: doc/BRIEF.md
# Conditional-Swap Bit Permuter

This block reorders a vector of 2^M bits according to a secret permutation. The permutation is given as a flat vector of swap-control bits that some other block computes in advance. The data crosses 2M-1 stages. Each stage pairs up every bit position with exactly one partner a fixed stride away, and exchanges the two bits when the matching control bit is set. The number of ones in the vector never changes, so the block suits secret-dependent reordering where the timing must not depend on the data.

Each exchange is applied as an XOR mask, not through a selector. The difference of the two bits is ANDed with the control bit and then XORed into both positions. A parameter picks one of two builds. The pipelined build has a register after every stage and a valid bit that travels with the data, and each stage's control slice travels alongside the data. The combinational build gives the result in the same cycle.

Top module: `bnp_benes_permuter`

## Requirements
- R1: In the pipelined build (PIPELINED=1), out_valid at a clock edge equals in_valid sampled 2M-1 edges earlier. A vector accepted with in_valid appears on out_data with that same latency, and back-to-back vectors and gaps are both allowed.
- R2: in_ctrl holds (2M-1)·2^(M-1) bits. Stage k (k = 0 first) uses bits k·2^(M-1) + p, where p = a·2^s + b is the pair number inside the stage.
- R3: Stage k uses stride s = M-1-k for k < M and s = k-M+1 for k >= M. This gives the order M-1 down to 0 and back up to M-1.
- R4: In a stage with stride s, pair p = a·2^s + b joins the positions a·2^(s+1)+b and a·2^(s+1)+2^s+b. The two bits exchange when the control bit is 1 and stay in place when it is 0.
- R5: An all-zero in_ctrl gives out_data equal to in_data.
- R6: Every stage, and so the whole block, keeps the number of ones in the vector.
- R7: While rst_n is low, and for the first 2M-1 edges after its release, out_valid is 0 (pipelined build).
- R8: In the combinational build (PIPELINED=0), out_data is the permuted in_data in the same cycle and out_valid equals in_valid.
- R9: In the pipelined build, the stage registers load only with a valid vector. Once the last vector has left, out_data holds its value while in_valid stays low, whatever in_data and in_ctrl do.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock (pipelined build) |
| rst_n | input | 1 | Active-low reset of the valid chain |
| in_valid | input | 1 | Input vector and controls are valid |
| in_data | input | 2^M | Vector to be permuted |
| in_ctrl | input | (2M-1)·2^(M-1) | Swap-control bits, packed by stage, then by pair |
| out_valid | output | 1 | out_data holds a permuted vector |
| out_data | output | 2^M | Permuted vector |

## Verification
The single-control-bit sweep drives one set control bit per vector. It uses the data patterns 5555, 3333, 0F0F and 00FF, whose bits differ at distances 1, 2, 4 and 8. A mistaken stride, stage order, pair index or control packing therefore moves a bit that can be seen. All-zero controls separate a correct identity from any stray exchange. All-ones controls and fully random controls exercise every pair at once, and the popcount is compared on each result. Streams with random gaps in in_valid show whether valid and each stage's control slice stay aligned with the data. A separate small instance of the combinational build is swept over the same kinds of patterns.

// File: rtl/bnp_pkg.sv
package bnp_pkg;

   // Stride of stage k in a network of order m: m-1 .. 0 .. m-1
   function automatic int unsigned stage_stride(int unsigned m, int unsigned k);
      return (k < m) ? (m - 1 - k) : (k - m + 1);
   endfunction

   // Lower position of pair p (p = a*2^s + b) in a stage of stride s
   function automatic int unsigned pair_lo(int unsigned s, int unsigned p);
      int unsigned a;
      int unsigned b;
      a = p >> s;
      b = p & ((32'd1 << s) - 32'd1);
      return (a << (s + 1)) + b;
   endfunction

endpackage

// File: rtl/bnp_swap_net.sv
module bnp_swap_net
   import bnp_pkg::*;
#(
   parameter int unsigned M      = 4,
   parameter int unsigned STRIDE = 0,
   localparam int unsigned N     = 2 ** M,
   localparam int unsigned H     = N / 2
) (
   input  logic [N-1:0] x_in,
   input  logic [H-1:0] sel,
   output logic [N-1:0] x_out
);

   localparam int unsigned DIST = 2 ** STRIDE;

   if (STRIDE >= M) begin : g_bad_stride
      $error("bnp_swap_net: STRIDE must be below M");
   end

   logic [N-1:0] mask;

   // Each position belongs to exactly one pair, so every mask bit is written once
   always_comb begin
      mask = '0;
      for (int unsigned p = 0; p < H; p++) begin
         int unsigned lo;
         logic        y;
         lo = pair_lo(STRIDE, p);
         y  = (x_in[lo] ^ x_in[lo + DIST]) & sel[p];
         mask[lo]        = y;
         mask[lo + DIST] = y;
      end
   end

   assign x_out = x_in ^ mask;

endmodule

// File: rtl/bnp_stage.sv
module bnp_stage
   import bnp_pkg::*;
#(
   parameter int unsigned M          = 4,
   parameter int unsigned STRIDE     = 0,
   parameter bit          REGISTERED = 1'b1,
   localparam int unsigned N         = 2 ** M,
   localparam int unsigned H         = N / 2
) (
   input  logic         clk,
   input  logic         rst_n,
   input  logic         d_valid,
   input  logic [N-1:0] d_data,
   input  logic [H-1:0] d_sel,
   output logic         q_valid,
   output logic [N-1:0] q_data
);

   logic [N-1:0] x_swp;

   bnp_swap_net #(
      .M      (M),
      .STRIDE (STRIDE)
   ) u_net (
      .x_in  (d_data),
      .sel   (d_sel),
      .x_out (x_swp)
   );

   if (REGISTERED) begin : g_reg
      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n) q_valid <= 1'b0;
         else        q_valid <= d_valid;
      end

      // Datapath carries no reset; it loads only with a valid vector
      always_ff @(posedge clk) begin
         if (d_valid) q_data <= x_swp;
      end
   end else begin : g_comb
      assign q_valid = d_valid;
      assign q_data  = x_swp;
   end

endmodule

// File: rtl/bnp_ctl_hop.sv
module bnp_ctl_hop #(
   parameter int unsigned W          = 8,
   parameter bit          REGISTERED = 1'b1
) (
   input  logic         clk,
   input  logic         en,
   input  logic [W-1:0] d,
   output logic [W-1:0] q
);

   if (W < 1) begin : g_bad_w
      $error("bnp_ctl_hop: W must be at least 1");
   end

   if (REGISTERED) begin : g_reg
      always_ff @(posedge clk) begin
         if (en) q <= d;
      end
   end else begin : g_comb
      assign q = d;
   end

endmodule

// File: rtl/bnp_benes_permuter.sv
module bnp_benes_permuter
   import bnp_pkg::*;
#(
   parameter int unsigned M         = 4,
   parameter bit          PIPELINED = 1'b1,
   localparam int unsigned N        = 2 ** M,
   localparam int unsigned H        = N / 2,
   localparam int unsigned NSTG     = 2 * M - 1,
   localparam int unsigned CW       = NSTG * H
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic          in_valid,
   input  logic [N-1:0]  in_data,
   input  logic [CW-1:0] in_ctrl,
   output logic          out_valid,
   output logic [N-1:0]  out_data
);

   if (M < 1 || M > 10) begin : g_bad_m
      $error("bnp_benes_permuter: M must lie in 1..10");
   end

   logic [N-1:0] dat [NSTG+1];
   logic [NSTG:0] vld;

   assign dat[0] = in_data;
   assign vld[0] = in_valid;

   for (genvar k = 0; k < NSTG; k++) begin : g_stg
      localparam int unsigned RW = (NSTG - k) * H;

      // Control bits still owed to this stage and all later ones
      logic [RW-1:0] rem;

      if (k == 0) begin : g_head
         assign rem = in_ctrl;
      end else begin : g_hop
         bnp_ctl_hop #(
            .W          (RW),
            .REGISTERED (PIPELINED)
         ) u_hop (
            .clk (clk),
            .en  (vld[k-1]),
            .d   (g_stg[k-1].rem[RW+H-1:H]),
            .q   (rem)
         );
      end

      bnp_stage #(
         .M          (M),
         .STRIDE     (stage_stride(M, k)),
         .REGISTERED (PIPELINED)
      ) u_stage (
         .clk     (clk),
         .rst_n   (rst_n),
         .d_valid (vld[k]),
         .d_data  (dat[k]),
         .d_sel   (rem[H-1:0]),
         .q_valid (vld[k+1]),
         .q_data  (dat[k+1])
      );
   end

   assign out_valid = vld[NSTG];
   assign out_data  = dat[NSTG];

endmodule

// File: rtl/bnp_benes_permuter_chk.sv
module bnp_stage_chk
   import bnp_pkg::*;
#(
   parameter int unsigned M      = 4,
   parameter int unsigned STRIDE = 0,
   localparam int unsigned N     = 2 ** M,
   localparam int unsigned H     = N / 2
) (
   input logic         clk,
   input logic         rst_n,
   input logic         d_valid,
   input logic [N-1:0] d_data,
   input logic [H-1:0] d_sel,
   input logic [N-1:0] x_swp
);

   localparam int unsigned DIST = 2 ** STRIDE;
   localparam int unsigned LO_Z = pair_lo(STRIDE, H - 1);

   // R6
   pop_keep_chk: assert property (@(posedge clk) disable iff (!rst_n)
      d_valid |-> ($countones(x_swp) == $countones(d_data)));

   // R5
   zero_sel_ident_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (d_valid && d_sel == '0) |-> (x_swp == d_data));

   // R4
   pair_first_chk: assert property (@(posedge clk) disable iff (!rst_n)
      d_valid |-> (x_swp[0] == (d_sel[0] ? d_data[DIST] : d_data[0])));

   // R4
   pair_last_chk: assert property (@(posedge clk) disable iff (!rst_n)
      d_valid |-> (x_swp[LO_Z + DIST] == (d_sel[H-1] ? d_data[LO_Z] : d_data[LO_Z + DIST])));

endmodule

module bnp_benes_permuter_chk #(
   parameter int unsigned M         = 4,
   parameter bit          PIPELINED = 1'b1
) (
   input logic clk,
   input logic rst_n,
   input logic out_valid
);

   localparam int unsigned NSTG = 2 * M - 1;

   if (PIPELINED) begin : g_pipe
      logic [7:0] since;

      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n)                since <= '0;
         else if (since < 8'(NSTG)) since <= since + 8'd1;
      end

      // R7
      early_valid_chk: assert property (@(posedge clk) disable iff (!rst_n)
         (since < 8'(NSTG)) |-> !out_valid);
   end

endmodule

bind bnp_stage bnp_stage_chk #(
   .M      (M),
   .STRIDE (STRIDE)
) u_stage_chk (
   .clk     (clk),
   .rst_n   (rst_n),
   .d_valid (d_valid),
   .d_data  (d_data),
   .d_sel   (d_sel),
   .x_swp   (x_swp)
);

bind bnp_benes_permuter bnp_benes_permuter_chk #(
   .M         (M),
   .PIPELINED (PIPELINED)
) u_chk (
   .clk       (clk),
   .rst_n     (rst_n),
   .out_valid (out_valid)
);

// File: tb/bnp_benes_permuter_bench.sv
`timescale 1ns/1ps
module bnp_benes_permuter_bench;

   localparam int unsigned M    = 4;
   localparam int unsigned N    = 16;
   localparam int unsigned NSTG = 7;
   localparam int unsigned CW   = 56;
   localparam int unsigned MC   = 3;
   localparam int unsigned NC   = 8;
   localparam int unsigned CWC  = 20;

   logic clk = 1'b0;
   logic rst_n = 1'b0;
   always #10 clk = ~clk;

   logic          in_valid = 1'b0;
   logic [N-1:0]  in_data = '0;
   logic [CW-1:0] in_ctrl = '0;
   logic          out_valid;
   logic [N-1:0]  out_data;

   logic           c_valid = 1'b0;
   logic [NC-1:0]  c_data = '0;
   logic [CWC-1:0] c_ctrl = '0;
   logic           c_out_valid;
   logic [NC-1:0]  c_out_data;

   bnp_benes_permuter #(.M(M), .PIPELINED(1'b1)) u_bnp_benes_permuter (
      .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_data(in_data),
      .in_ctrl(in_ctrl), .out_valid(out_valid), .out_data(out_data));

   bnp_benes_permuter #(.M(MC), .PIPELINED(1'b0)) u_bnp_benes_permuter_comb (
      .clk(clk), .rst_n(rst_n), .in_valid(c_valid), .in_data(c_data),
      .in_ctrl(c_ctrl), .out_valid(c_out_valid), .out_data(c_out_data));

   int n_chk = 0;
   int n_bad = 0;
   bit done = 1'b0;
   logic [N-1:0] exp_q [256];
   logic [NSTG-1:0] vh = '0;

   task automatic check(input bit ok, input string req, input logic [63:0] act, input logic [63:0] exp);
      n_chk++;
      if (!ok) begin
         n_bad++;
         $display("FAIL %s actual=%h expected=%h", req, act, exp);
      end
   endtask

   // Swap-by-swap model following the stride order and pair enumeration
   function automatic logic [63:0] ref_perm(input int m, input logic [63:0] v, input logic [127:0] c);
      logic [63:0] r;
      int idx;
      int s;
      int i;
      int j;
      logic t;
      r = v;
      idx = 0;
      for (int k = 0; k < 2*m-1; k++) begin
         s = (k < m) ? (m - 1 - k) : (k - m + 1);
         for (int a = 0; a < (1 << (m-1-s)); a++) begin
            for (int b = 0; b < (1 << s); b++) begin
               i = a * (1 << (s+1)) + b;
               j = i + (1 << s);
               if (c[idx]) begin
                  t = r[i]; r[i] = r[j]; r[j] = t;
               end
               idx++;
            end
         end
      end
      return r;
   endfunction

   function automatic logic [CW-1:0] rnd_ctrl();
      return {$urandom, $urandom};
   endfunction

   // mode 0: zero ctrl, 1: single ctrl bit sweep, 2: random, 3: all ones, 4: random with gaps
   task automatic run_burst(input int count, input int mode, input string req);
      int sent;
      int rd;
      int guard;
      logic [15:0] pats [4];
      sent = 0;
      rd = 0;
      guard = 0;
      pats[0] = 16'h5555; pats[1] = 16'h3333; pats[2] = 16'h0F0F; pats[3] = 16'h00FF;
      while (rd < count && guard < count * 4 + 50) begin
         @(negedge clk);
         guard++;
         // R1: out_valid follows the valid driven NSTG edges earlier
         check(out_valid == vh[NSTG-1], "R1 valid latency", 64'(out_valid), 64'(vh[NSTG-1]));
         if (out_valid) begin
            check(out_data == exp_q[rd], req, 64'(out_data), 64'(exp_q[rd]));
            // R6
            check($countones(out_data) == $countones(exp_q[rd]), "R6 popcount",
                  64'($countones(out_data)), 64'($countones(exp_q[rd])));
            rd++;
         end
         if (sent < count && (mode != 4 || ($urandom % 3) != 0)) begin
            case (mode)
               0: begin in_data = 16'($urandom); in_ctrl = '0; end
               1: begin
                  in_data = pats[(sent / CW) % 4];
                  in_ctrl = CW'(1) << (sent % CW);
               end
               3: begin in_data = 16'($urandom); in_ctrl = '1; end
               default: begin in_data = 16'($urandom); in_ctrl = rnd_ctrl(); end
            endcase
            in_valid = 1'b1;
            exp_q[sent] = N'(ref_perm(M, 64'(in_data), 128'(in_ctrl)));
            if (mode == 0) exp_q[sent] = in_data; // R5: identity
            sent++;
         end else begin
            in_valid = 1'b0;
            in_data = 16'($urandom);
            in_ctrl = rnd_ctrl();
         end
         vh = {vh[NSTG-2:0], in_valid};
      end
      check(rd == count, {req, " drain"}, 64'(rd), 64'(count));
   endtask

   initial begin
      logic [N-1:0] held;
      int lat;
      logic [N-1:0] exp1;
      repeat (3) @(negedge clk);
      // R7: reset state
      check(out_valid == 1'b0, "R7 reset", 64'(out_valid), 64'd0);
      rst_n = 1'b1;
      repeat (2) @(negedge clk);
      check(out_valid == 1'b0, "R7 after release", 64'(out_valid), 64'd0);

      // R1: single vector latency
      in_valid = 1'b1;
      in_data = 16'hA5C3;
      in_ctrl = rnd_ctrl();
      exp1 = N'(ref_perm(M, 64'(in_data), 128'(in_ctrl)));
      lat = 0;
      for (int c = 1; c <= 12 && lat == 0; c++) begin
         @(negedge clk);
         in_valid = 1'b0;
         if (out_valid) lat = c;
      end
      check(lat == NSTG, "R1 latency", 64'(lat), 64'(NSTG));
      check(out_data == exp1, "R1 data", 64'(out_data), 64'(exp1));
      repeat (NSTG + 2) @(negedge clk);

      run_burst(40, 0, "R5 zero ctrl identity");
      run_burst(224, 1, "R2 R3 R4 single ctrl bit");
      run_burst(30, 3, "R4 all ones ctrl");
      run_burst(200, 2, "R4 random ctrl");
      run_burst(200, 4, "R1 R2 gapped stream");

      // R9: output holds while in_valid stays low
      repeat (NSTG + 2) @(negedge clk);
      held = out_data;
      for (int c = 0; c < 12; c++) begin
         in_valid = 1'b0;
         in_data = 16'($urandom);
         in_ctrl = rnd_ctrl();
         @(negedge clk);
         check(out_data == held && !out_valid, "R9 hold", 64'(out_data), 64'(held));
      end

      // R8: combinational build, single bit sweep then random
      for (int i = 0; i < 2 * CWC + 64; i++) begin
         @(negedge clk);
         c_valid = (i % 2) == 0;
         if (i < 2 * CWC) begin
            c_data = (i < CWC) ? 8'h55 : 8'h0F;
            c_ctrl = CWC'(1) << (i % CWC);
         end else begin
            c_data = 8'($urandom);
            c_ctrl = CWC'($urandom);
         end
         #2;
         check(c_out_data == NC'(ref_perm(MC, 64'(c_data), 128'(c_ctrl))), "R8 comb data",
               64'(c_out_data), ref_perm(MC, 64'(c_data), 128'(c_ctrl)));
         check(c_out_valid == c_valid, "R8 comb valid", 64'(c_out_valid), 64'(c_valid));
      end
      c_ctrl = '0;
      c_data = 8'hB2;
      #2;
      check(c_out_data == 8'hB2, "R8 R5 comb identity", 64'(c_out_data), 64'hB2);

      done = 1'b1;
      $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
      $finish;
   end

   initial begin
      #(20 * 150000);
      if (!done) begin
         n_chk++;
         n_bad++;
         $display("FAIL watchdog actual=hung expected=finished");
         $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
         $finish;
      end
   end

endmodule